// File: doc/BRIEF.md
# Result Signature Compactor and Checker

This block sits beside a processor under test and watches the result words that the processor writes to its data memory. Each accepted word is folded into one short running signature. By default the fold is a CRC-style LFSR that takes a whole word per clock. Three other fold modes can be chosen instead: a modular sum, a plain XOR, and a two-way parity mode. The parity mode keeps a column parity across all words and a parity bit for each row of a small block of words.

When the run ends, the test driver raises a done input. The block then freezes the signature and compares it in hardware with an expected value supplied to the device. The result is one registered pass bit that can drive a status LED. A separate done flag tells "still running" apart from "finished but wrong". This replaces reading back memory contents with a check of one bit.

Top module: `result_sig_checker`

## Requirements
- R1: While rst_ni is low and after it is released, done_o and pass_o are 0. The signature register is seeded with all ones and the row parity bits with zeros, so a run with no words ends with a signature of all ones.
- R2: With mode_i = 0 (CRC), each accepted word is shifted in MSB first. For each bit, the feedback is the signature MSB XOR the data bit. The signature shifts left by one and is XORed with POLY (default 0x04C11DB7) when the feedback is 1.
- R3: With mode_i = 1 (sum), each accepted word is added to the signature modulo 2^SIG_W.
- R4: With mode_i = 2 (XOR), each accepted word is XORed into the signature.
- R5: With mode_i = 3 (parity), each accepted word is XORed into a column accumulator. Its reduction parity is also XORed into row bit k, where k is the count of words accepted so far modulo ROW_BLK (first word: k = 0). The compared signature is the column accumulator XOR the ROW_BLK row bits placed in its top bits.
- R6: A word is accepted only on a clock edge where valid_i is 1. Data on other cycles has no effect.
- R7: On the first clock edge where done_i is 1, done_o becomes 1 and pass_o becomes 1 exactly when the signature equals expected_i sampled at that edge.
- R8: A word presented with valid_i on the same edge as the first done_i is not folded into the compared signature.
- R9: Once done_o is 1, further valid_i, data_i, done_i and expected_i activity is ignored. done_o and pass_o hold their values until reset.
- R10: pass_o is 0 whenever done_o is 0.
- R11: In CRC mode, leading all-zero words change the signature away from the all-ones seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Fold mode: 0 CRC, 1 sum, 2 XOR, 3 row/column parity; held static during a run |
| valid_i | input | 1 | Result word strobe |
| data_i | input | SIG_W | Result word |
| done_i | input | 1 | End of run |
| expected_i | input | SIG_W | Expected signature |
| done_o | output | 1 | Run finished and verdict captured |
| pass_o | output | 1 | Signature matched; meaningful while done_o is 1 |

## Verification
The in-line assertions check four things on every cycle. The signature holds on cycles with no accepted word and after the run ends. The row index stays in range. pass_o is never 1 without done_o. The verdict and done flag do not change once captured.

The fold arithmetic of each mode can only be shown by the bench's scenarios, which compare pass_o against signatures computed independently for random word streams with idle gaps. The same applies to the exclusion of a word that coincides with done, the effect of zero words on the seed, and the detection of a one-bit error in the expected value.

// File: rtl/sig_chk_pkg.sv
package sig_chk_pkg;
  typedef enum logic [1:0] {
    FOLD_CRC = 2'd0,
    FOLD_SUM = 2'd1,
    FOLD_XOR = 2'd2,
    FOLD_PAR = 2'd3
  } fold_mode_e;
endpackage

// File: rtl/sig_fold.sv
module sig_fold
  import sig_chk_pkg::*;
#(
  parameter int          SIG_W = 32,
  parameter logic [SIG_W-1:0] POLY = 32'h04C11DB7
) (
  input  fold_mode_e       mode_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SIG_W-1:0] word_i,
  output logic [SIG_W-1:0] next_o
);
  logic [SIG_W-1:0] crc;
  logic             fb;

  // one word per cycle: SIG_W serial LFSR steps unrolled
  always_comb begin
    crc = sig_i;
    fb  = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      fb  = crc[SIG_W-1] ^ word_i[i];
      crc = {crc[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    unique case (mode_i)
      FOLD_CRC: next_o = crc;
      FOLD_SUM: next_o = sig_i + word_i;
      default:  next_o = sig_i ^ word_i;  // XOR and column parity
    endcase
  end
endmodule

// File: rtl/sig_row_par.sv
module sig_row_par #(
  parameter int SIG_W   = 32,
  parameter int ROW_BLK = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SIG_W-1:0]   word_i,
  output logic [ROW_BLK-1:0] row_o
);
  localparam int IDX_W = (ROW_BLK > 1) ? $clog2(ROW_BLK) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROW_BLK - 1);

  logic [IDX_W-1:0] idx_q;
  logic             word_par;

  assign word_par = ^word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idx_q <= '0;
    else if (en_i)               idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
  end

  for (genvar k = 0; k < ROW_BLK; k++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              row_o[k] <= 1'b0;
      else if (en_i && idx_q == IDX_W'(k))      row_o[k] <= row_o[k] ^ word_par;
    end
  end

  assert_row_idx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST);
  assert_row_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(row_o) && $stable(idx_q));
endmodule

// File: rtl/sig_verdict.sv
module sig_verdict #(
  parameter int SIG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SIG_W-1:0] exp_i,
  output logic             done_o,
  output logic             pass_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (done_i && !done_o) begin
      done_o <= 1'b1;
      pass_o <= (sig_i == exp_i);
    end
  end

  assert_verdict_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(pass_o));
  assert_pass_needs_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !pass_o);
  assert_done_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !done_o) |=> done_o);
endmodule

// File: rtl/result_sig_checker.sv
module result_sig_checker
  import sig_chk_pkg::*;
#(
  parameter int SIG_W   = 32,
  parameter int ROW_BLK = 8,
  parameter logic [SIG_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             valid_i,
  input  logic [SIG_W-1:0] data_i,
  input  logic             done_i,
  input  logic [SIG_W-1:0] expected_i,
  output logic             done_o,
  output logic             pass_o
);
  localparam int PAD_W = SIG_W - ROW_BLK;

  fold_mode_e         mode;
  logic               accept;
  logic [SIG_W-1:0]   sig_q, sig_next, sig_cmp;
  logic [ROW_BLK-1:0] row;

  assign mode   = fold_mode_e'(mode_i);
  // a word coinciding with done, or any word after it, is dropped
  assign accept = valid_i && !done_i && !done_o;

  sig_fold #(.SIG_W(SIG_W), .POLY(POLY)) u_fold (
    .mode_i (mode),
    .sig_i  (sig_q),
    .word_i (data_i),
    .next_o (sig_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= '1;
    else if (accept) sig_q <= sig_next;
  end

  sig_row_par #(.SIG_W(SIG_W), .ROW_BLK(ROW_BLK)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (accept && mode == FOLD_PAR),
    .word_i (data_i),
    .row_o  (row)
  );

  assign sig_cmp = (mode == FOLD_PAR) ? (sig_q ^ {row, {PAD_W{1'b0}}}) : sig_q;

  sig_verdict #(.SIG_W(SIG_W)) u_verdict (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done_i),
    .sig_i  (sig_cmp),
    .exp_i  (expected_i),
    .done_o (done_o),
    .pass_o (pass_o)
  );

  assert_sig_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sig_q));
  assert_sig_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || done_i) |=> $stable(sig_q));
endmodule

// File: tb/result_sig_checker_tb.sv
`timescale 1ns/1ps
module result_sig_checker_tb_top;
  localparam int W   = 32;
  localparam int BLK = 8;
  localparam logic [W-1:0] POLY = 32'h04C11DB7;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         done_i = 1'b0;
  logic [W-1:0] expected_i = '0;
  logic         done_o, pass_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0]   m_sig;
  logic [BLK-1:0] m_row;
  int             m_cnt;

  always #5 clk_i = ~clk_i;

  result_sig_checker #(.SIG_W(W), .ROW_BLK(BLK), .POLY(POLY)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .valid_i(valid_i),
    .data_i(data_i), .done_i(done_i), .expected_i(expected_i),
    .done_o(done_o), .pass_o(pass_o)
  );

  function automatic logic [W-1:0] crc_word(logic [W-1:0] s, logic [W-1:0] d);
    for (int i = W - 1; i >= 0; i--) begin
      if (s[W-1] ^ d[i]) s = (s << 1) ^ POLY;
      else               s = s << 1;
    end
    return s;
  endfunction

  function automatic logic [W-1:0] model_final();
    if (mode_i == 2'd3) return m_sig ^ ({{(W-BLK){1'b0}}, m_row} << (W - BLK));
    return m_sig;
  endfunction

  task automatic model_push(logic [W-1:0] w);
    case (mode_i)
      2'd0: m_sig = crc_word(m_sig, w);
      2'd1: m_sig = m_sig + w;
      2'd2: m_sig = m_sig ^ w;
      default: begin
        m_sig = m_sig ^ w;
        m_row[m_cnt % BLK] = m_row[m_cnt % BLK] ^ (^w);
      end
    endcase
    m_cnt++;
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0; mode_i = m; valid_i = 1'b0; done_i = 1'b0;
    m_sig = '1; m_row = '0; m_cnt = 0;
    @(negedge clk_i);
    check("R1 done_o in reset", W'(done_o), '0);
    check("R1 pass_o in reset", W'(pass_o), '0);
    rst_ni = 1'b1;
  endtask

  task automatic push(logic [W-1:0] w);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = w;
    @(posedge clk_i);
    model_push(w);
  endtask

  task automatic idle_cycle(bit chk);
    @(negedge clk_i);
    valid_i = 1'b0; data_i = $urandom;
    if (chk) begin
      check("R10 done_o before done", W'(done_o), '0);
      check("R10 pass_o before done", W'(pass_o), '0);
    end
    @(posedge clk_i);
  endtask

  task automatic finish_run(string req, logic [W-1:0] exp, bit junk);
    logic want;
    want = (exp == model_final());
    @(negedge clk_i);
    done_i = 1'b1; expected_i = exp; valid_i = junk; data_i = $urandom | 32'h1;
    @(posedge clk_i);
    @(negedge clk_i);
    done_i = 1'b0; valid_i = 1'b0;
    check({req, " done_o"}, W'(done_o), 1);
    check({req, " pass_o"}, W'(pass_o), W'(want));
  endtask

  task automatic post_junk();
    logic held;
    held = pass_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1; data_i = $urandom; expected_i = $urandom;
      done_i = i[0];
      @(posedge clk_i);
    end
    @(negedge clk_i);
    valid_i = 1'b0; done_i = 1'b0;
    check("R9 pass_o held", W'(pass_o), W'(held));
    check("R9 done_o held", W'(done_o), 1);
  endtask

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic scenario(logic [1:0] m, int n, bit good, bit junk);
    logic [W-1:0] exp;
    do_reset(m);
    for (int i = 0; i < n; i++) begin
      push($urandom);
      if ($urandom % 3 == 0) idle_cycle(0);  // R6 idle data ignored
    end
    idle_cycle(1);
    exp = model_final();
    if (!good) exp = exp ^ (32'h1 << ($urandom % W));
    finish_run(junk ? {mode_req(m), " R8"} : mode_req(m), exp, junk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: empty run ends at the all-ones seed in every mode
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      finish_run("R1 seed", '1, 0);
    end
    // R11: zero words move the CRC away from the seed
    do_reset(2'd0);
    for (int i = 0; i < 4; i++) push('0);
    idle_cycle(1);
    finish_run("R11 zeros vs seed", '1, 0);
    check("R11 pass_o low", W'(pass_o), '0);
    do_reset(2'd0);
    for (int i = 0; i < 4; i++) push('0);
    finish_run("R11 zeros model", model_final(), 0);
    // main fold modes, matched and corrupted expectations
    for (int m = 0; m < 4; m++) begin
      scenario(2'(m), 5 + int'($urandom % 20), 1, 0);
      post_junk();
      scenario(2'(m), 5 + int'($urandom % 20), 0, 0);
      post_junk();
      scenario(2'(m), 12 + int'($urandom % 30), 1, 1);
    end
    // parity mode across several row blocks
    scenario(2'd3, 3 * BLK + 3, 1, 0);
    scenario(2'd3, 3 * BLK + 3, 0, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule